// File: doc/BRIEF.md
# DRAM cell access demonstrator sequencer

This block walks a single one-transistor memory cell through one access at a time, so that each phase can be shown on five LED groups. The groups are the word line, the cell, the bit line on the cell side of the sense amplifier (the upper group), the sense amplifier, and the bit line on the far side (the lower group). Each group is lit at one of three brightness levels: dark, half or full. Half brightness is a 50% duty pulse stream.

An operator presses a debounced button once per phase. The block starts at rest with the bit lines half-charged. It then goes through charge sharing, where the word line opens and the cell drops to half. Next comes sense firing, where the sense amplifier drives the bit line pair to full swing. A write phase follows when the chosen operation writes a value. Precharge then closes the word line and returns the bit lines to half. The value kept in the cell is held inside the block and is also shown on a port.

Top module: `dram_cell_demo`

## Requirements
- R1: While `rst_n` is low, step pulses have no effect. When reset ends, `phase_o` is 0 (idle) and `bit_o` is 0.
- R2: Phases have these codes: 0 idle, 1 charge share, 2 sense fire, 3 write, 4 precharge. They only move 0→1→2→(3)→4→0. `op_i` is sampled once, on the step that leaves idle. Its codes are 0 read, 1 write 0, 2 write 1, 3 read. Later changes to `op_i` do not affect that access.
- R3: Each rising edge of `step_i` advances exactly one phase. A step held high for several cycles advances only once.
- R4: In idle, the word line and sense amplifier are dark, the cell is full when `bit_o`=1 and dark when it is 0, and both bit line groups are at half.
- R5: In charge share, the word line is full, the cell is at half, the sense amplifier is dark, and both bit lines are at half.
- R6: In sense fire, the word line and sense amplifier are full. The cell and the upper bit line follow the stored bit (full for 1, dark for 0), and the lower bit line shows its complement.
- R7: In write, the word line and sense amplifier are full. The cell and the upper bit line show the written value, and the lower bit line shows its complement.
- R8: In precharge, the word line and sense amplifier are dark, both bit lines are at half, and the cell shows the value now stored.
- R9: `bit_o` changes only on the step that leaves the write phase, and it takes the written value. A read goes from sense fire straight to precharge and leaves `bit_o` as it was.
- R10: Dark is constant 0 and full is constant 1. Half is high for exactly 128 of any 256 consecutive cycles, driven from the top bit of an 8-bit free-running counter. The LED outputs come from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Debounced advance button |
| op_i | input | 2 | Operation: 0 read, 1 write 0, 2 write 1, 3 read |
| led_wl_o | output | 1 | Word line LED drive |
| led_cell_o | output | 1 | Cell LED drive |
| led_bl_up_o | output | 1 | Cell-side bit line LED drive |
| led_sa_o | output | 1 | Sense amplifier LED drive |
| led_bl_lo_o | output | 1 | Far-side bit line LED drive |
| phase_o | output | 3 | Current phase code |
| bit_o | output | 1 | Value held in the cell |

## Verification
The hardest case to reach is a sense-fire pattern that depends on a stored bit left behind by earlier writes. The bench also has to show that `op_i` changes made after the access starts are ignored. Random sequences of operations build up that history, with `op_i` scrambled after the first step and the step button held for random lengths. Directed accesses first cover a read of 0, a write of the same value, a write of the opposite value, and the second read code. Each brightness level is measured by counting high cycles over a 256-cycle window.

// File: rtl/dram_cell_demo.sv
module dram_cell_demo #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic [1:0] op_i,
  output logic       led_wl_o,
  output logic       led_cell_o,
  output logic       led_bl_up_o,
  output logic       led_sa_o,
  output logic       led_bl_lo_o,
  output logic [2:0] phase_o,
  output logic       bit_o
);
  localparam logic [2:0] PH_IDLE  = 3'd0;
  localparam logic [2:0] PH_SHARE = 3'd1;
  localparam logic [2:0] PH_SENSE = 3'd2;
  localparam logic [2:0] PH_WRITE = 3'd3;
  localparam logic [2:0] PH_PRE   = 3'd4;

  localparam logic [1:0] LV_OFF  = 2'd0;
  localparam logic [1:0] LV_HALF = 2'd1;
  localparam logic [1:0] LV_FULL = 2'd2;

  logic [2:0]       phase_q;
  logic             bit_q;
  logic             step_q;
  logic [1:0]       op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       lv_wl, lv_cell, lv_up, lv_sa, lv_lo;

  wire adv      = step_i & ~step_q;
  wire is_write = op_q[1] ^ op_q[0];
  wire wval     = op_q[1];
  wire half     = cnt_q[CNT_W-1];

  function automatic logic [1:0] lv_of(input logic b);
    return b ? LV_FULL : LV_OFF;
  endfunction

  function automatic logic drive(input logic [1:0] lv, input logic h);
    return (lv == LV_FULL) | ((lv == LV_HALF) & h);
  endfunction

  always_comb begin
    lv_wl   = LV_OFF;
    lv_sa   = LV_OFF;
    lv_cell = lv_of(bit_q);
    lv_up   = LV_HALF;
    lv_lo   = LV_HALF;
    case (phase_q)
      PH_SHARE: begin
        lv_wl   = LV_FULL;
        lv_cell = LV_HALF;
      end
      PH_SENSE: begin
        lv_wl   = LV_FULL;
        lv_sa   = LV_FULL;
        lv_cell = lv_of(bit_q);
        lv_up   = lv_of(bit_q);
        lv_lo   = lv_of(~bit_q);
      end
      PH_WRITE: begin
        lv_wl   = LV_FULL;
        lv_sa   = LV_FULL;
        lv_cell = lv_of(wval);
        lv_up   = lv_of(wval);
        lv_lo   = lv_of(~wval);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bit_q       <= 1'b0;
      step_q      <= 1'b0;
      op_q        <= 2'd0;
      cnt_q       <= '0;
      led_wl_o    <= 1'b0;
      led_cell_o  <= 1'b0;
      led_bl_up_o <= 1'b0;
      led_sa_o    <= 1'b0;
      led_bl_lo_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      step_q <= step_i;
      if (adv) begin
        case (phase_q)
          PH_IDLE: begin
            phase_q <= PH_SHARE;
            op_q    <= op_i;
          end
          PH_SHARE: phase_q <= PH_SENSE;
          PH_SENSE: phase_q <= is_write ? PH_WRITE : PH_PRE;
          PH_WRITE: begin
            phase_q <= PH_PRE;
            bit_q   <= wval;
          end
          default:  phase_q <= PH_IDLE;
        endcase
      end
      led_wl_o    <= drive(lv_wl, half);
      led_cell_o  <= drive(lv_cell, half);
      led_bl_up_o <= drive(lv_up, half);
      led_sa_o    <= drive(lv_sa, half);
      led_bl_lo_o <= drive(lv_lo, half);
    end
  end

  assign phase_o = phase_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/dram_cell_demo_chk.sv
module dram_cell_demo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_i,
  input logic       led_wl_o,
  input logic       led_cell_o,
  input logic       led_bl_up_o,
  input logic       led_sa_o,
  input logic       led_bl_lo_o,
  input logic [2:0] phase_o,
  input logic       bit_o
);
  p_legal_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |->
      (($past(phase_o) == 3'd0 && phase_o == 3'd1) ||
       ($past(phase_o) == 3'd1 && phase_o == 3'd2) ||
       ($past(phase_o) == 3'd2 && (phase_o == 3'd3 || phase_o == 3'd4)) ||
       ($past(phase_o) == 3'd3 && phase_o == 3'd4) ||
       ($past(phase_o) == 3'd4 && phase_o == 3'd0)));

  p_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> ($past(step_i) && !$past(step_i, 2)));

  p_idle_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && $past(phase_o) == 3'd0) |-> (!led_wl_o && !led_sa_o && led_cell_o == bit_o));

  p_share_wl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && $past(phase_o) == 3'd1) |-> (led_wl_o && !led_sa_o));

  p_sense_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2 && $past(phase_o) == 3'd2) |->
      (led_wl_o && led_sa_o && led_cell_o == bit_o && led_bl_up_o == bit_o && led_bl_lo_o == !bit_o));

  p_write_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3 && $past(phase_o) == 3'd3) |->
      (led_wl_o && led_sa_o && led_cell_o == led_bl_up_o && led_bl_lo_o == !led_bl_up_o));

  p_pre_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd4 && $past(phase_o) == 3'd4) |-> (!led_wl_o && !led_sa_o && led_cell_o == bit_o));

  p_bit_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_o != $past(bit_o)) |-> ($past(phase_o) == 3'd3 && phase_o == 3'd4));
endmodule

bind dram_cell_demo dram_cell_demo_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .led_wl_o    (led_wl_o),
  .led_cell_o  (led_cell_o),
  .led_bl_up_o (led_bl_up_o),
  .led_sa_o    (led_sa_o),
  .led_bl_lo_o (led_bl_lo_o),
  .phase_o     (phase_o),
  .bit_o       (bit_o)
);

// File: tb/dram_cell_demo_tb_top.sv
`timescale 1ns/1ps
module dram_cell_demo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic       led_wl_o, led_cell_o, led_bl_up_o, led_sa_o, led_bl_lo_o;
  logic [2:0] phase_o;
  logic       bit_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int cnt[5];
  bit model_bit = 0;

  always #2.5 clk = ~clk;

  dram_cell_demo dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i),
    .led_wl_o(led_wl_o), .led_cell_o(led_cell_o), .led_bl_up_o(led_bl_up_o),
    .led_sa_o(led_sa_o), .led_bl_lo_o(led_bl_lo_o),
    .phase_o(phase_o), .bit_o(bit_o)
  );

  function automatic int lvl(int ph, bit s, bit w, int g);
    int full = 256;
    case (ph)
      0: case (g) 0: return 0; 1: return s ? full : 0; 3: return 0; default: return 128; endcase
      1: case (g) 0: return full; 3: return 0; default: return 128; endcase
      2: case (g) 0, 3: return full; 1, 2: return s ? full : 0; default: return s ? 0 : full; endcase
      3: case (g) 0, 3: return full; 1, 2: return w ? full : 0; default: return w ? 0 : full; endcase
      default: case (g) 0, 3: return 0; 1: return s ? full : 0; default: return 128; endcase
    endcase
  endfunction

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_step(int len);
    @(negedge clk) step_i = 1'b1;
    repeat (len - 1) @(negedge clk);
    @(negedge clk) step_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure();
    for (int g = 0; g < 5; g++) cnt[g] = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cnt[0] += led_wl_o; cnt[1] += led_cell_o; cnt[2] += led_bl_up_o;
      cnt[3] += led_sa_o; cnt[4] += led_bl_lo_o;
    end
  endtask

  task automatic check_phase(int ph, bit s, bit w);
    string tags[5] = '{"R4", "R5", "R6", "R7", "R8"};
    string names[5] = '{"wl", "cell", "bl_up", "sa", "bl_lo"};
    check_eq("R2", "phase", phase_o, ph);
    measure();
    for (int g = 0; g < 5; g++) begin
      int e = lvl(ph, s, w, g);
      check_eq(tags[ph], names[g], cnt[g], e);
      if (e == 128) check_eq("R10", {"half ", names[g]}, cnt[g], 128);
    end
  endtask

  task automatic access(bit [1:0] op, int hold);
    bit wr = op[1] ^ op[0];
    bit w = op[1];
    bit s = model_bit;
    op_i = op;
    do_step(hold);
    op_i = 2'($urandom);
    check_phase(1, s, w);
    do_step(1);
    check_phase(2, s, w);
    do_step(hold);
    if (wr) begin
      check_phase(3, s, w);
      check_eq("R9", "bit held in write", bit_o, s);
      do_step(1);
      model_bit = w;
    end
    check_eq("R9", "bit after write/read", bit_o, model_bit);
    check_phase(4, model_bit, w);
    do_step(1);
    check_phase(0, model_bit, w);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    step_i = 1'b1; @(negedge clk); step_i = 1'b0; @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1", "phase after reset", phase_o, 0);
    check_eq("R1", "bit after reset", bit_o, 0);
    check_phase(0, 0, 0);
    access(2'd0, 1);
    access(2'd2, 4);
    access(2'd3, 1);
    access(2'd2, 2);
    access(2'd1, 3);
    access(2'd0, 1);
    for (int k = 0; k < 16; k++) access(2'($urandom), 1 + int'($urandom_range(0, 4)));
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule